// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a countdown watchdog with a small 32-bit register port. Software arms it by programming a coarse reload value and a clock divider, enabling it, and then issuing restart writes often enough to keep the count from reaching zero. Each control register accepts a write only if the written word carries that register's own key pattern. A restart takes effect only when the written word equals one exact restart word. This makes it unlikely that stray writes from a runaway program disable or feed the watchdog.

The bus clock is divided by 8, 64, 512 or 4096. The countdown start is the 12-bit reload field shifted left by a scale parameter, which is 12 bits (times 4096) by default. When the count expires the block latches a status flag. It can then emit a reset pulse of 2, 4, 8 or 16 bus cycles, an interrupt level that holds until the next valid restart, or both.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, mode reads 0 (disabled, both outputs off, pulse code 0). Control reads reload 0xFFF with divider select 3. Status reads 0, and the reset pulse and interrupt outputs are low.
- R2: A write to offset 0x0 (mode) is accepted only when bits 23:12 equal 0xABC. Bit 0 is enable, bit 1 is reset-output enable, bit 2 is interrupt enable, and bits 5:4 are the pulse code. A read at 0x0 returns exactly these fields, with every other bit zero.
- R3: A write to offset 0x4 (control) is accepted only when bits 25:14 equal 0x248, which is the word constant 0x00920000. Bits 13:2 are the reload field and bits 1:0 are the divider select. A read at 0x4 returns only these fields.
- R4: A write of exactly 0x00001999 to offset 0x8 reloads the count to reload << SCALE_SHIFT, restarts the divider phase and clears the status and the interrupt. Any other word written there changes nothing.
- R5: Divider select 0, 1, 2 and 3 divide by 8, 64, 512 and 4096. The count drops by one per divided tick.
- R6: With a reload start value L ≥ 1 and divide D, status bit 0 (read at 0xC) becomes 1 on the clock edge exactly L·D enabled cycles after the restart write edge.
- R7: While the enable bit is 0 the count and the divider phase hold. After re-enabling, the remaining cycles of the period are counted.
- R8: With reset output enabled, expiry drives the reset pulse high for 2 << code bus cycles, starting on the edge that sets status.
- R9: With interrupt enabled, expiry raises the interrupt on the edge that sets status. It stays high until a valid restart write, and it stays low if interrupt enable is 0.
- R10: A reload field of 0 expires on the first divided tick after the restart, D cycles after the restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, including key bits |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wdt_rst | output | 1 | Timed reset pulse on expiry |
| wdt_irq | output | 1 | Expiry interrupt level |

## Verification
A wrong count value or divider phase shows up only as a status flag, pulse or interrupt that arrives early or late. The bench therefore samples status on the exact expected edge and on the edge before it, for every divider select and several reload values, so an error of a single cycle is visible. A wrongly accepted key or restart word shows up at once in the register readback, or as an expiry that does not land on the edge predicted from the last valid restart. A stuck pulse counter shows up as a reset pulse whose width differs from 2 << code within 16 cycles of expiry.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam logic [11:0] MODE_KEY  = 12'hABC;
  localparam logic [11:0] CTRL_KEY  = 12'h248;
  localparam logic [31:0] KICK_WORD = 32'h0000_1999;

  localparam logic [3:0] OFS_MODE = 4'h0;
  localparam logic [3:0] OFS_CTRL = 4'h4;
  localparam logic [3:0] OFS_KICK = 4'h8;
  localparam logic [3:0] OFS_STAT = 4'hC;

  typedef struct packed {
    logic [1:0] plen;
    logic       irq_en;
    logic       rst_en;
    logic       en;
  } mode_t;

  typedef struct packed {
    logic [11:0] reload;
    logic [1:0]  sel;
  } ctrl_t;

  // Divide ratio picked by the control select field.
  function automatic logic [12:0] prescale_div(input logic [1:0] sel);
    case (sel)
      2'd0:    return 13'd8;
      2'd1:    return 13'd64;
      2'd2:    return 13'd512;
      default: return 13'd4096;
    endcase
  endfunction

  // Reset pulse width in bus cycles for a pulse code.
  function automatic logic [4:0] pulse_len(input logic [1:0] code);
    return 5'd2 << code;
  endfunction

endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output mode_t       mode_q,
  output ctrl_t       ctrl_q,
  output logic        mode_ok,
  output logic        ctrl_ok,
  output logic        kick_ok
);

  assign mode_ok = wr && (addr == OFS_MODE) && (wdata[23:12] == MODE_KEY);
  assign ctrl_ok = wr && (addr == OFS_CTRL) && (wdata[25:14] == CTRL_KEY);
  assign kick_ok = wr && (addr == OFS_KICK) && (wdata == KICK_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctrl_q <= '{reload: 12'hFFF, sel: 2'd3};
    end else begin
      if (mode_ok) begin
        mode_q.en     <= wdata[0];
        mode_q.rst_en <= wdata[1];
        mode_q.irq_en <= wdata[2];
        mode_q.plen   <= wdata[5:4];
      end
      if (ctrl_ok) begin
        ctrl_q.sel    <= wdata[1:0];
        ctrl_q.reload <= wdata[13:2];
      end
    end
  end

endmodule

// File: rtl/kwd_tick.sv
module kwd_tick
  import kwd_pkg::*;
#(
  parameter int PRE_W = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] sel,
  input  logic       kick_ok,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  assign limit = PRE_W'(prescale_div(sel) - 13'd1);
  assign tick  = en && (pre_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (kick_ok) pre_q <= '0;
    else if (tick)    pre_q <= '0;
    else if (en)      pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
  parameter int FIELD_W     = 12,
  parameter int SCALE_SHIFT = 12,
  localparam int CNT_W      = FIELD_W + SCALE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               kick_ok,
  input  logic [FIELD_W-1:0] reload,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               status_q,
  output logic               fire
);

  function automatic logic [CNT_W-1:0] start_count(input logic [FIELD_W-1:0] f);
    return CNT_W'(f) << SCALE_SHIFT;
  endfunction

  assign fire = tick && !kick_ok && !status_q && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= start_count('1);
      status_q <= 1'b0;
    end else if (kick_ok) begin
      cnt_q    <= start_count(reload);
      status_q <= 1'b0;
    end else begin
      if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (fire) status_q <= 1'b1;
    end
  end

endmodule

// File: rtl/kwd_alarm.sv
module kwd_alarm
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       kick_ok,
  input  logic       rst_en,
  input  logic       irq_en,
  input  logic [1:0] plen,
  output logic       rst_pulse,
  output logic       irq_q
);

  logic [4:0] pc_q;

  assign rst_pulse = (pc_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (fire && rst_en) pc_q <= pulse_len(plen);
      else if (pc_q != '0) pc_q <= pc_q - 1'b1;
      if (kick_ok) irq_q <= 1'b0;
      else if (fire && irq_en) irq_q <= 1'b1;
    end
  end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int FIELD_W     = 12,
  parameter int SCALE_SHIFT = 12,
  parameter int PRE_W       = 13,
  localparam int CNT_W      = FIELD_W + SCALE_SHIFT
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_rst,
  output logic        wdt_irq
);

  mode_t            mode_q;
  ctrl_t            ctrl_q;
  logic             mode_ok, ctrl_ok, kick_ok;
  logic             tick, fire, status_q;
  logic [CNT_W-1:0] cnt_q;

  kwd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .mode_q(mode_q), .ctrl_q(ctrl_q),
    .mode_ok(mode_ok), .ctrl_ok(ctrl_ok), .kick_ok(kick_ok)
  );

  kwd_tick #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(mode_q.en), .sel(ctrl_q.sel),
    .kick_ok(kick_ok), .tick(tick)
  );

  kwd_count #(.FIELD_W(FIELD_W), .SCALE_SHIFT(SCALE_SHIFT)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick_ok(kick_ok),
    .reload(FIELD_W'(ctrl_q.reload)),
    .cnt_q(cnt_q), .status_q(status_q), .fire(fire)
  );

  kwd_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .fire(fire), .kick_ok(kick_ok),
    .rst_en(mode_q.rst_en), .irq_en(mode_q.irq_en), .plen(mode_q.plen),
    .rst_pulse(wdt_rst), .irq_q(wdt_irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_MODE: bus_rdata = {26'd0, mode_q.plen, 1'b0, mode_q.irq_en, mode_q.rst_en, mode_q.en};
      OFS_CTRL: bus_rdata = {18'd0, ctrl_q.reload, ctrl_q.sel};
      OFS_STAT: bus_rdata = {31'd0, status_q};
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/kwd_chk.sv
module kwd_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr,
  input logic [3:0]       addr,
  input logic [31:0]      wdata,
  input logic [4:0]       mode_bits,
  input logic             en,
  input logic             rst_en,
  input logic             tick,
  input logic             fire,
  input logic             kick_ok,
  input logic [CNT_W-1:0] cnt,
  input logic             status,
  input logic             irq,
  input logic             rst_pulse
);

  // R6
  fire_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> status);

  // R4
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok |=> (!status && !irq));

  // R7
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !kick_ok) |=> $stable(cnt));

  // R5
  tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);

  // R8
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rst_en) |=> rst_pulse);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !kick_ok) |=> irq);

  // R2
  mode_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 4'h0 && wdata[23:12] != 12'hABC) |=> $stable(mode_bits));

endmodule

bind keyed_watchdog kwd_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
  .mode_bits(mode_q), .en(mode_q.en), .rst_en(mode_q.rst_en),
  .tick(tick), .fire(fire), .kick_ok(kick_ok), .cnt(cnt_q),
  .status(status_q), .irq(wdt_irq), .rst_pulse(wdt_rst)
);

// File: tb/tb_keyed_watchdog.sv
`timescale 1ns/1ps
module tb_keyed_watchdog;

  localparam int SHIFT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst, wdt_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keyed_watchdog #(.SCALE_SHIFT(SHIFT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst), .wdt_irq(wdt_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] mode_word(input bit en, input bit re, input bit ie, input int code);
    return 32'h00AB_C000 | (32'(code) << 4) | (32'(ie) << 2) | (32'(re) << 1) | 32'(en);
  endfunction

  function automatic logic [31:0] ctrl_word(input int field, input int sel);
    return 32'h0092_0000 | (32'(field) << 2) | 32'(sel);
  endfunction

  function automatic int period(input int field, input int sel);
    int d = 8 << (3 * sel);
    return (field == 0) ? d : (field << SHIFT) * d;
  endfunction

  task automatic kick();
    bus_write(4'h8, 32'h0000_1999);
  endtask

  // Arms with the given setup and checks status edge-exactly.
  task automatic run_timeout(input string tag, input int field, input int sel);
    logic [31:0] r;
    int p = period(field, sel);
    bus_write(4'h4, ctrl_word(field, sel));
    bus_write(4'h0, mode_word(1, 0, 1, 0));
    kick();
    wait_n(p - 1);
    bus_read(4'hC, r);
    check({tag, " before expiry"}, r, 32'd0);
    wait_n(1);
    bus_read(4'hC, r);
    check({tag, " at expiry"}, r, 32'd1);
    check({tag, " R9 irq at expiry"}, {31'd0, wdt_irq}, 32'd1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired before the test finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int highs;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    bus_read(4'h0, r); check("R1 mode", r, 32'h0);
    bus_read(4'h4, r); check("R1 ctrl", r, 32'h3FFF);
    bus_read(4'hC, r); check("R1 status", r, 32'h0);
    check("R1 rst out", {31'd0, wdt_rst}, 32'd0);
    check("R1 irq out", {31'd0, wdt_irq}, 32'd0);

    // R2 mode key
    bus_write(4'h0, mode_word(0, 1, 1, 2));
    bus_read(4'h0, r); check("R2 keyed write", r, 32'h26);
    bus_write(4'h0, 32'h00AB_D031);
    bus_read(4'h0, r); check("R2 wrong key", r, 32'h26);
    bus_write(4'h0, 32'h0000_0031);
    bus_read(4'h0, r); check("R2 no key", r, 32'h26);
    bus_write(4'h0, 32'hFF00_0000 | mode_word(1, 0, 0, 3));
    bus_read(4'h0, r); check("R2 extra bits dropped", r, 32'h31);
    bus_write(4'h0, mode_word(0, 0, 0, 0));

    // R3 control key
    bus_write(4'h4, ctrl_word(5, 1));
    bus_read(4'h4, r); check("R3 keyed write", r, 32'h15);
    bus_write(4'h4, 32'h0091_0000 | (32'd7 << 2) | 32'd2);
    bus_read(4'h4, r); check("R3 wrong key", r, 32'h15);

    // R5/R6 sweep over selects and reload values
    for (int f = 1; f <= 3; f++) run_timeout($sformatf("R6 R5 sel0 field%0d", f), f, 0);
    for (int s = 1; s <= 3; s++) run_timeout($sformatf("R5 R6 sel%0d field1", s), 1, s);

    // R10 zero reload
    run_timeout("R10 zero reload", 0, 0);

    // R8 pulse widths, interrupt disabled
    for (int c = 0; c < 4; c++) begin
      bus_write(4'h4, ctrl_word(1, 0));
      bus_write(4'h0, mode_word(1, 1, 0, c));
      kick();
      wait_n(31);
      check($sformatf("R8 code%0d low before", c), {31'd0, wdt_rst}, 32'd0);
      highs = 0;
      for (int k = 0; k < 24; k++) begin
        wait_n(1);
        if (k == 0) check($sformatf("R8 code%0d starts at expiry", c), {31'd0, wdt_rst}, 32'd1);
        if (wdt_rst) highs++;
      end
      check($sformatf("R8 code%0d width", c), 32'(highs), 32'(2 << c));
      check($sformatf("R9 code%0d irq stays low", c), {31'd0, wdt_irq}, 32'd0);
    end

    // R9 interrupt hold and R4 bad restart ignored
    run_timeout("R9 arm", 1, 0);
    wait_n(50);
    check("R9 irq held", {31'd0, wdt_irq}, 32'd1);
    bus_write(4'h8, 32'h0000_1998);
    check("R4 bad kick keeps irq", {31'd0, wdt_irq}, 32'd1);
    bus_read(4'hC, r); check("R4 bad kick keeps status", r, 32'd1);
    kick();
    check("R9 irq cleared", {31'd0, wdt_irq}, 32'd0);
    bus_read(4'hC, r); check("R4 status cleared", r, 32'd0);

    // R4 bad restart midway does not move expiry
    bus_write(4'h4, ctrl_word(2, 0));
    kick();
    wait_n(30);
    bus_write(4'h8, 32'h0000_1998);
    wait_n(32);
    bus_read(4'hC, r); check("R4 ignored kick before", r, 32'd0);
    wait_n(1);
    bus_read(4'hC, r); check("R4 ignored kick at expiry", r, 32'd1);

    // R4 valid restart midway restarts the period
    kick();
    wait_n(30);
    kick();
    wait_n(63);
    bus_read(4'hC, r); check("R4 rekick before", r, 32'd0);
    wait_n(1);
    bus_read(4'hC, r); check("R4 rekick at expiry", r, 32'd1);

    // R7 freeze and resume
    bus_write(4'h4, ctrl_word(3, 0));
    kick();
    wait_n(10);
    bus_write(4'h0, mode_word(0, 0, 1, 0));
    wait_n(200);
    bus_read(4'hC, r); check("R7 frozen", r, 32'd0);
    bus_write(4'h0, mode_word(1, 0, 1, 0));
    wait_n(84);
    bus_read(4'hC, r); check("R7 resumed before", r, 32'd0);
    wait_n(1);
    bus_read(4'hC, r); check("R7 resumed at expiry", r, 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule